// File: doc/BRIEF.md
# Two-Bit Branch Direction and Target Predictor

This block is a small direct-mapped prediction table for a pipelined processor. A branch's fetch address selects one entry using the address bits just above the instruction alignment bits. Each entry holds the last taken target seen for that slot and a two-bit saturating confidence counter. The decode stage presents a branch address on the lookup port. In the same cycle it gets back a taken or not-taken prediction and the address to fetch next. That address is the stored target when the prediction is taken, and the next sequential instruction address otherwise.

Once a branch resolves after execute, the pipeline presents the branch address, the actual outcome and the actual target on the update port with a valid strobe. The indexed entry changes on that clock edge. The table has no tags, so addresses that share index bits share an entry.

Each counter is a four-state machine: SNT (00, strongly not taken), WNT (01, weakly not taken), WT (10, weakly taken) and ST (11, strongly taken). A taken outcome moves the counter one step towards ST: SNT->WNT, WNT->WT, WT->ST, and ST->ST as a hold. A not-taken outcome moves it one step towards SNT: ST->WT, WT->WNT, WNT->SNT, and SNT->SNT as a hold. Synchronous reset forces every entry to SNT and clears every stored target.

Top module: `bpred_table`

## Requirements
- R1: The entry used is selected by address bits [4:2] (bits [ALIGN_W+IDX_W-1:ALIGN_W]). Two addresses with equal bits there share one entry, whatever their other bits.
- R2: While rst is high at a clock edge, every counter is set to SNT (00), so every later lookup predicts not taken until the entry is trained again.
- R3: A valid update with up_taken=1 moves the indexed counter one state up (00->01->10->11), and 11 stays 11.
- R4: A valid update with up_taken=0 moves the indexed counter one state down (11->10->01->00), and 00 stays 00.
- R5: When the looked-up counter is 10 or 11, lk_taken is 1 and lk_next equals the entry's stored target.
- R6: When the looked-up counter is 00 or 01, lk_taken is 0 and lk_next equals lk_pc+4, wrapping modulo 2^ADDR_W.
- R7: A valid taken update stores up_target in the indexed entry. A valid not-taken update leaves the stored target unchanged.
- R8: An update takes effect at the clock edge where up_valid is high. A lookup of the same entry in that cycle returns the value from before the update.
- R9: With up_valid low, no entry changes, whatever the other update inputs are.
- R10: An update changes only the entry its address indexes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | ADDR_W | Branch address being looked up at decode |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_next | output | ADDR_W | Predicted next fetch address |
| up_valid | input | 1 | Update strobe from the resolve stage |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |
| up_target | input | ADDR_W | Resolved taken target |

## Verification
The hardest cases to reach are the saturation holds at both ends of the counter and the retained target. Getting to them needs a run of same-direction updates to one entry, followed by a not-taken update that carries a junk target address. The stimulus table trains a single entry up to ST and pushes it once more. It then walks the entry back down to SNT and past it, checking the lookup of that entry in every cycle. Because the lookup and the update share a cycle, each step also shows the pre-update value. Aliasing is reached with a second address that differs only above the index bits.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_state_t;
endpackage

// File: rtl/bpred_ctr_fsm.sv
module bpred_ctr_fsm
    import bpred_pkg::*;
(
    input  ctr_state_t cur,
    input  logic       taken,
    output ctr_state_t nxt
);
    always_comb begin
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_SNT;
        endcase
    end
endmodule

// File: rtl/bpred_entry.sv
module bpred_entry
    import bpred_pkg::*;
#(
    parameter int TGT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_taken,
    input  logic [TGT_W-1:0] wr_target,
    output ctr_state_t       ctr,
    output logic [TGT_W-1:0] target
);
    ctr_state_t ctr_nxt;

    bpred_ctr_fsm u_fsm (
        .cur   (ctr),
        .taken (wr_taken),
        .nxt   (ctr_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)        ctr <= CTR_SNT;
        else if (wr_en) ctr <= ctr_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)                    target <= '0;
        else if (wr_en && wr_taken) target <= wr_target;
    end

    // R2
    rst_clear_chk: assert property (@(posedge clk) rst |=> (ctr == CTR_SNT && target == '0));

    // R3
    sat_high_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && ctr == CTR_ST) |=> ctr == CTR_ST);

    // R3
    leave_low_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && ctr == CTR_SNT) |=> ctr == CTR_WNT);

    // R4
    sat_low_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && ctr == CTR_SNT) |=> ctr == CTR_SNT);

    // R4
    leave_high_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && ctr == CTR_ST) |=> ctr == CTR_WT);

    // R7
    keep_target_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken) |=> $stable(target));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(ctr) && $stable(target)));
endmodule

// File: rtl/bpred_table.sv
module bpred_table
    import bpred_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = 3,
    parameter int ALIGN_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_next,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1 << ALIGN_W);

    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  up_idx;
    logic [ENTRIES-1:0] wr_en_vec;
    ctr_state_t        ctr_arr [ENTRIES];
    logic [ADDR_W-1:0] tgt_arr [ENTRIES];
    ctr_state_t        lk_state;
    logic [ADDR_W-1:0] lk_tgt;

    assign lk_idx = lk_pc[ALIGN_W +: IDX_W];
    assign up_idx = up_pc[ALIGN_W +: IDX_W];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign wr_en_vec[g] = up_valid && (up_idx == IDX_W'(g));

        bpred_entry #(.TGT_W(ADDR_W)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_en_vec[g]),
            .wr_taken  (up_taken),
            .wr_target (up_target),
            .ctr       (ctr_arr[g]),
            .target    (tgt_arr[g])
        );
    end

    assign lk_state = ctr_arr[lk_idx];
    assign lk_tgt   = tgt_arr[lk_idx];

    always_comb begin
        unique case (lk_state)
            CTR_WT, CTR_ST: begin
                lk_taken = 1'b1;
                lk_next  = lk_tgt;
            end
            default: begin
                lk_taken = 1'b0;
                lk_next  = lk_pc + PC_STEP;
            end
        endcase
    end

    // R10
    single_write_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_en_vec));

    // R9
    no_write_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !up_valid |-> wr_en_vec == '0);
endmodule

// File: tb/bpred_table_bench.sv
`timescale 1ns/1ps
module bpred_table_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] lk_pc = 16'h0100;
    logic        lk_taken;
    logic [15:0] lk_next;
    logic        up_valid = 1'b0;
    logic [15:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [15:0] up_target = '0;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    bpred_table u_bpred_table (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_next(lk_next),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target)
    );

    typedef struct packed {
        logic        uv;
        logic [15:0] upc;
        logic        ut;
        logic [15:0] utg;
        logic [15:0] lpc;
        logic        et;
        logic [15:0] en;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0100, 1'b0, 16'h0104}, // R6 fresh entry
        '{1'b1, 16'h0100, 1'b1, 16'h0200, 16'h0100, 1'b0, 16'h0104}, // R8 old value seen
        '{1'b1, 16'h0100, 1'b1, 16'h0200, 16'h0100, 1'b0, 16'h0104}, // R3 00->01
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0100, 1'b1, 16'h0200}, // R5 counter 10
        '{1'b1, 16'h0100, 1'b1, 16'h0240, 16'h0100, 1'b1, 16'h0200}, // R8 new target not yet
        '{1'b1, 16'h0100, 1'b1, 16'h0240, 16'h0100, 1'b1, 16'h0240}, // R7 target rewritten
        '{1'b1, 16'h0100, 1'b0, 16'hFFFF, 16'h0100, 1'b1, 16'h0240}, // R3 saturated at 11
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0100, 1'b1, 16'h0240}, // R4 11->10, R7 kept
        '{1'b1, 16'h0100, 1'b0, 16'h0000, 16'h0100, 1'b1, 16'h0240}, // R5 still 10
        '{1'b1, 16'h0100, 1'b0, 16'h0000, 16'h0100, 1'b0, 16'h0104}, // R4 10->01
        '{1'b1, 16'h0100, 1'b0, 16'h0000, 16'h0100, 1'b0, 16'h0104}, // R4 01->00
        '{1'b1, 16'h0100, 1'b1, 16'h0300, 16'h0104, 1'b0, 16'h0108}, // R10 neighbour untouched
        '{1'b1, 16'h0100, 1'b1, 16'h0300, 16'h0120, 1'b0, 16'h0124}, // R4 stayed 00, now 01
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0120, 1'b1, 16'h0300}, // R1 alias shares entry
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0104, 1'b0, 16'h0108}, // R10 neighbour
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 16'hFFFC, 1'b0, 16'h0000}, // R6 wrap
        '{1'b0, 16'h0108, 1'b1, 16'h0500, 16'h0108, 1'b0, 16'h010C}, // R9 strobe low
        '{1'b0, 16'h0108, 1'b1, 16'h0500, 16'h0108, 1'b0, 16'h010C}, // R9 strobe low
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0108, 1'b0, 16'h010C}  // R9 entry still 00
    };

    task automatic check(input string req, input logic et, input logic [15:0] en);
        n_checks++;
        if (lk_taken !== et || lk_next !== en) begin
            n_fails++;
            $display("FAIL %s: got taken=%0b next=%h, expected taken=%0b next=%h",
                     req, lk_taken, lk_next, et, en);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 10000) begin
            n_fails++;
            $display("FAIL watchdog: got %0d cycles, expected under 10000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check("R2", 1'b0, 16'h0104);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            up_valid  = VEC[i].uv;
            up_pc     = VEC[i].upc;
            up_taken  = VEC[i].ut;
            up_target = VEC[i].utg;
            lk_pc     = VEC[i].lpc;
            #1 check($sformatf("vector %0d (R1/R3-R10)", i), VEC[i].et, VEC[i].en);
            @(negedge clk);
        end
        up_valid = 1'b0;
        lk_pc = 16'h0100;
        #1 check("R5 trained entry before reset", 1'b1, 16'h0300);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 check("R2 counter cleared by reset", 1'b0, 16'h0104);
        lk_pc = 16'h0120;
        #1 check("R2 alias after reset", 1'b0, 16'h0124);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule